// File: doc/BRIEF.md
# Descriptor Cache Flush Command Executor

This block takes flush commands for a descriptor cache and runs each one through a small sequencer. A command names a 40-bit descriptor address, a 16-bit tag and a status-request bit, plus option flags. The flags select a queue drain before the flush, a keep-valid write-out, a second flush of the companion descriptor, a whole-cache flush, and use of one of four address-blocking slots. The cache storage, the queue drain engine and the memory writeback live outside. Each of them is reached through a request/done handshake.

The block keeps four blocking slots. Each slot holds a descriptor address that cache accesses must not touch until software frees it. It also keeps one whole-cache block flag. A lookup port compares a query address with every held slot in parallel and reports whether that access must stall. A separate unblock port frees a single slot or clears the whole-cache block. Slot misuse is checked before any request reaches the cache. Releasing a free slot, or blocking a slot that is still held, ends the command with an error code and no flush.

Top module: `flush_cmd_exec`

## Requirements
- R1: `cmdReady` is high exactly when the executor is idle, including the cycle after reset. While it is high, no drain, flush or whole-cache request is active. A command is taken in a cycle where `cmdValid` and `cmdReady` are both high, and `cmdReady` is low in the following cycle.
- R2: A command with the release option whose selected slot is free ends with status code 2'b01. It issues no drain, flush or whole-cache request and leaves every slot unchanged.
- R3: A command with the block option and without the release option whose selected slot is held ends with status code 2'b10. It issues no request, and the slot keeps its old address.
- R4: With the release option on a held slot, the slot is freed before the flush request is raised. A lookup of the old address is therefore no longer blocked while the flush runs.
- R5: With the block option, when the last flush completes, the selected slot captures the command address. From then on a lookup of that address reports blocked, while a lookup of an unheld address does not.
- R6: With the whole-cache option, only a whole-cache request is issued and all other option bits are ignored. After its done, every lookup reports blocked until an unblock of cache type arrives. The four slots are left as they were.
- R7: With the drain option, a drain request runs to its done before the first flush request is raised.
- R8: With the companion option, a second flush request with `flushExt` high follows the done of the primary flush, whose `flushExt` is low.
- R9: `flushKeep` equals the keep-valid option while a flush request is active.
- R10: A status pulse (`stsValid` for one cycle) carrying the command tag appears once per command only when the status-request bit is set. Code 2'b00 means success, and code 2'b11 never appears. Without the bit, no status appears.
- R11: An unblock pulse with `unbIsCache` high clears the whole-cache block. With `unbIsCache` low it frees the slot given by `unbSlot`.
- R12: At most one of the drain, flush and whole-cache requests is high at a time. A request stays high, with `reqAddr` stable, until its done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cmdValid | input | 1 | Flush command offered |
| cmdReady | output | 1 | Executor idle, command accepted |
| cmdTag | input | 16 | Command tag echoed in status |
| cmdWantStatus | input | 1 | Produce a status record |
| cmdAddr | input | 40 | Descriptor address |
| cmdSlot | input | 2 | Blocking slot index |
| cmdRelease | input | 1 | Free the slot before flushing |
| cmdBlock | input | 1 | Hold the slot on this address after the flush |
| cmdWhole | input | 1 | Flush the whole cache |
| cmdKeepValid | input | 1 | Write out but keep the line valid |
| cmdDrainFirst | input | 1 | Drain the queue before the flush |
| cmdExtDesc | input | 1 | Also flush the companion descriptor |
| unbValid | input | 1 | Unblock pulse |
| unbIsCache | input | 1 | 1: clear whole-cache block, 0: free slot |
| unbSlot | input | 2 | Slot to free |
| lkpAddr | input | 40 | Cache access address to test |
| lkpBlocked | output | 1 | Access must stall |
| reqAddr | output | 40 | Address for drain/flush requests |
| drainReq | output | 1 | Queue drain request |
| drainDone | input | 1 | Queue drain finished |
| flushReq | output | 1 | Descriptor flush request |
| flushExt | output | 1 | Flush targets the companion descriptor |
| flushKeep | output | 1 | Keep line valid after write-out |
| flushDone | input | 1 | Descriptor flush finished |
| wholeReq | output | 1 | Whole-cache flush request |
| wholeDone | input | 1 | Whole-cache flush finished |
| stsValid | output | 1 | Status pulse |
| stsTag | output | 16 | Tag of the finished command |
| stsCode | output | 2 | 00 ok, 01 released a free slot, 10 blocked a held slot |

## Verification
The assertions assume that the cache side raises a done only while the matching request is high, and lowers it again in the next cycle. They also assume that an unblock pulse never coincides with the completion of a command that touches the same slot or the whole-cache flag. The bench responder answers each request once, two cycles after it is seen, and drops its done at once. Unblock pulses are sent only while the executor is idle.

// File: rtl/flush_exec_pkg.sv
package flush_exec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_DRAIN, ST_FLUSH, ST_FLUSH_EXT, ST_WHOLE, ST_DONE
  } execState_t;

  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] STS_OK       = 2'b00;
  localparam logic [CODE_W-1:0] STS_REL_FREE = 2'b01;
  localparam logic [CODE_W-1:0] STS_BLK_HELD = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the offered command
    logic relSlot;   // free the selected slot
    logic blkSlot;   // hold the selected slot on the command address
    logic setWhole;  // raise the whole-cache block
  } execStrobe_t;
endpackage

// File: rtl/flush_exec_dp.sv
module flush_exec_dp
  import flush_exec_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int ADDR_W = 40,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  execStrobe_t       strobe,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic              cmdWantStatus,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic              cmdRelease,
  input  logic              cmdBlock,
  input  logic              cmdWhole,
  input  logic              cmdKeepValid,
  input  logic              cmdDrainFirst,
  input  logic              cmdExtDesc,
  input  logic              unbValid,
  input  logic              unbIsCache,
  input  logic [SLOT_W-1:0] unbSlot,
  input  logic [ADDR_W-1:0] lkpAddr,
  output logic              lkpBlocked,
  output logic [TAG_W-1:0]  regTag,
  output logic              regWant,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regRel,
  output logic              regBlk,
  output logic              regWhole,
  output logic              regKeep,
  output logic              regDrain,
  output logic              regExt,
  output logic              selHeld
);
  logic [SLOT_W-1:0] regSlot;
  logic [SLOTS-1:0]  slotHeld;
  logic [SLOTS-1:0]  slotHit;
  logic [ADDR_W-1:0] slotAddr [SLOTS];
  logic              wholeBlk;

  // command register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regTag   <= '0;
      regWant  <= 1'b0;
      regAddr  <= '0;
      regSlot  <= '0;
      regRel   <= 1'b0;
      regBlk   <= 1'b0;
      regWhole <= 1'b0;
      regKeep  <= 1'b0;
      regDrain <= 1'b0;
      regExt   <= 1'b0;
    end else if (strobe.capture) begin
      regTag   <= cmdTag;
      regWant  <= cmdWantStatus;
      regAddr  <= cmdAddr;
      regSlot  <= cmdSlot;
      regRel   <= cmdRelease;
      regBlk   <= cmdBlock;
      regWhole <= cmdWhole;
      regKeep  <= cmdKeepValid;
      regDrain <= cmdDrainFirst;
      regExt   <= cmdExtDesc;
    end
  end

  // blocking slots; the command update is written last and wins
  for (genvar i = 0; i < SLOTS; i++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotHeld[i] <= 1'b0;
        slotAddr[i] <= '0;
      end else begin
        if (unbValid && !unbIsCache && unbSlot == SLOT_W'(i))
          slotHeld[i] <= 1'b0;
        if (strobe.relSlot && regSlot == SLOT_W'(i))
          slotHeld[i] <= 1'b0;
        if (strobe.blkSlot && regSlot == SLOT_W'(i)) begin
          slotHeld[i] <= 1'b1;
          slotAddr[i] <= regAddr;
        end
      end
    end
    assign slotHit[i] = slotHeld[i] && (slotAddr[i] == lkpAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      wholeBlk <= 1'b0;
    else begin
      if (unbValid && unbIsCache) wholeBlk <= 1'b0;
      if (strobe.setWhole)        wholeBlk <= 1'b1;
    end
  end

  assign selHeld    = slotHeld[regSlot];
  assign lkpBlocked = wholeBlk || (|slotHit);
endmodule

// File: rtl/flush_exec_ctl.sv
module flush_exec_ctl
  import flush_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              regWant,
  input  logic              regRel,
  input  logic              regBlk,
  input  logic              regWhole,
  input  logic              regKeep,
  input  logic              regDrain,
  input  logic              regExt,
  input  logic              selHeld,
  input  logic              drainDone,
  input  logic              flushDone,
  input  logic              wholeDone,
  output logic              drainReq,
  output logic              flushReq,
  output logic              flushExt,
  output logic              flushKeep,
  output logic              wholeReq,
  output logic              stsValid,
  output logic [CODE_W-1:0] stsCode,
  output execStrobe_t       strobe
);
  execState_t state, stateNext;
  logic [CODE_W-1:0] code, codeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      code  <= STS_OK;
    end else begin
      state <= stateNext;
      code  <= codeNext;
    end
  end

  always_comb begin
    stateNext = state;
    codeNext  = code;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_EVAL;
        end
      end
      ST_EVAL: begin
        codeNext = STS_OK;
        if (regWhole) begin
          stateNext = ST_WHOLE;
        end else if (regRel && !selHeld) begin
          codeNext  = STS_REL_FREE;
          stateNext = ST_DONE;
        end else if (regBlk && !regRel && selHeld) begin
          codeNext  = STS_BLK_HELD;
          stateNext = ST_DONE;
        end else begin
          strobe.relSlot = regRel;
          stateNext      = regDrain ? ST_DRAIN : ST_FLUSH;
        end
      end
      ST_DRAIN: begin
        if (drainDone) stateNext = ST_FLUSH;
      end
      ST_FLUSH: begin
        if (flushDone) begin
          if (regExt) stateNext = ST_FLUSH_EXT;
          else begin
            strobe.blkSlot = regBlk;
            stateNext      = ST_DONE;
          end
        end
      end
      ST_FLUSH_EXT: begin
        if (flushDone) begin
          strobe.blkSlot = regBlk;
          stateNext      = ST_DONE;
        end
      end
      ST_WHOLE: begin
        if (wholeDone) begin
          strobe.setWhole = 1'b1;
          stateNext       = ST_DONE;
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign cmdReady  = (state == ST_IDLE);
  assign drainReq  = (state == ST_DRAIN);
  assign flushReq  = (state == ST_FLUSH) || (state == ST_FLUSH_EXT);
  assign flushExt  = (state == ST_FLUSH_EXT);
  assign flushKeep = flushReq && regKeep;
  assign wholeReq  = (state == ST_WHOLE);
  assign stsValid  = (state == ST_DONE) && regWant;
  assign stsCode   = code;
endmodule

// File: rtl/flush_cmd_exec.sv
module flush_cmd_exec
  import flush_exec_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int ADDR_W = 40,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic              cmdWantStatus,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic              cmdRelease,
  input  logic              cmdBlock,
  input  logic              cmdWhole,
  input  logic              cmdKeepValid,
  input  logic              cmdDrainFirst,
  input  logic              cmdExtDesc,
  input  logic              unbValid,
  input  logic              unbIsCache,
  input  logic [SLOT_W-1:0] unbSlot,
  input  logic [ADDR_W-1:0] lkpAddr,
  output logic              lkpBlocked,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              drainReq,
  input  logic              drainDone,
  output logic              flushReq,
  output logic              flushExt,
  output logic              flushKeep,
  input  logic              flushDone,
  output logic              wholeReq,
  input  logic              wholeDone,
  output logic              stsValid,
  output logic [TAG_W-1:0]  stsTag,
  output logic [CODE_W-1:0] stsCode
);
  execStrobe_t strobe;
  logic regWant, regRel, regBlk, regWhole, regKeep, regDrain, regExt, selHeld;

  flush_exec_dp #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS)) uDp (
    .clk, .rstN, .strobe,
    .cmdTag, .cmdWantStatus, .cmdAddr, .cmdSlot, .cmdRelease, .cmdBlock,
    .cmdWhole, .cmdKeepValid, .cmdDrainFirst, .cmdExtDesc,
    .unbValid, .unbIsCache, .unbSlot, .lkpAddr, .lkpBlocked,
    .regTag(stsTag), .regWant, .regAddr(reqAddr), .regRel, .regBlk,
    .regWhole, .regKeep, .regDrain, .regExt, .selHeld
  );

  flush_exec_ctl uCtl (
    .clk, .rstN, .cmdValid, .cmdReady,
    .regWant, .regRel, .regBlk, .regWhole, .regKeep, .regDrain, .regExt,
    .selHeld, .drainDone, .flushDone, .wholeDone,
    .drainReq, .flushReq, .flushExt, .flushKeep, .wholeReq,
    .stsValid, .stsCode, .strobe
  );
endmodule

// File: rtl/flush_cmd_exec_chk.sv
module flush_cmd_exec_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              drainReq,
  input logic              flushReq,
  input logic              flushExt,
  input logic              flushDone,
  input logic              wholeReq,
  input logic              wholeDone,
  input logic              unbValid,
  input logic              lkpBlocked,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              stsValid,
  input logic [1:0]        stsCode
);
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !(drainReq || flushReq || wholeReq)); // R1
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({drainReq, flushReq, wholeReq})); // R12
  AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !flushDone) |=> (flushReq && $stable(reqAddr))); // R12
  AST_EXT_AFTER_PRIMARY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flushExt) |-> $past(flushReq && flushDone)); // R8
  AST_WHOLE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (wholeReq && wholeDone && !unbValid) |=> lkpBlocked); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    stsValid |-> (stsCode != 2'b11)); // R10
endmodule

bind flush_cmd_exec flush_cmd_exec_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk, .rstN, .cmdReady, .drainReq, .flushReq, .flushExt, .flushDone,
  .wholeReq, .wholeDone, .unbValid, .lkpBlocked, .reqAddr, .stsValid, .stsCode
);

// File: tb/sim_flush_cmd_exec.sv
`timescale 1ns/1ps
module sim_flush_cmd_exec;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, cmdReady, cmdWantStatus = 0;
  logic [15:0] cmdTag = 0;
  logic [39:0] cmdAddr = 0, lkpAddr = 0, reqAddr;
  logic [1:0] cmdSlot = 0, unbSlot = 0, stsCode;
  logic cmdRelease = 0, cmdBlock = 0, cmdWhole = 0, cmdKeepValid = 0;
  logic cmdDrainFirst = 0, cmdExtDesc = 0;
  logic unbValid = 0, unbIsCache = 0, lkpBlocked;
  logic drainReq, flushReq, flushExt, flushKeep, wholeReq, stsValid;
  logic drainDone = 0, flushDone = 0, wholeDone = 0;
  logic [15:0] stsTag;

  always #2.5 clk = ~clk;

  flush_cmd_exec u0 (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  int evLog[$];
  logic [17:0] expQ[$];
  logic sawKeep, probeAtFlush;
  bit busy = 0;
  int cdown = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // cache-side responder: answers each request two cycles after seeing it
  always @(negedge clk) begin
    if (drainDone || flushDone || wholeDone) begin
      drainDone = 0; flushDone = 0; wholeDone = 0;
    end else if (rstN && (drainReq || flushReq || wholeReq)) begin
      if (!busy) begin
        busy = 1; cdown = 2;
        if (flushReq) sawKeep = flushKeep;
        if (flushReq && !flushExt) probeAtFlush = lkpBlocked;
      end else begin
        cdown--;
        if (cdown == 0) begin
          busy = 0;
          if (drainReq) begin drainDone = 1; evLog.push_back(1); end
          else if (wholeReq) begin wholeDone = 1; evLog.push_back(4); end
          else begin flushDone = 1; evLog.push_back(flushExt ? 3 : 2); end
        end
      end
    end
  end

  // status monitor (scoreboard)
  always @(negedge clk) begin
    if (rstN && stsValid) begin
      if (expQ.size() == 0) chk(0, "R10 unexpected status", {stsTag, stsCode}, 0);
      else begin
        logic [17:0] e;
        e = expQ.pop_front();
        chk({stsTag, stsCode} == e, "R10 status tag/code", {stsTag, stsCode}, e);
      end
    end
  end

  task automatic issue(input logic [15:0] tag, input bit want, input logic [39:0] addr,
                       input logic [1:0] slot, input bit rel, input bit blk, input bit whole,
                       input bit keep, input bit drain, input bit ext, input logic [1:0] expCode);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    evLog.delete();
    cmdTag = tag; cmdWantStatus = want; cmdAddr = addr; cmdSlot = slot;
    cmdRelease = rel; cmdBlock = blk; cmdWhole = whole; cmdKeepValid = keep;
    cmdDrainFirst = drain; cmdExtDesc = ext; cmdValid = 1;
    if (want) expQ.push_back({tag, expCode});
    @(posedge clk); #1;
    cmdValid = 0;
    chk(cmdReady == 0, "R1 busy after accept", cmdReady, 0);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
  endtask

  task automatic lookup(input logic [39:0] a, input bit exp, input string req);
    lkpAddr = a; #1;
    chk(lkpBlocked == exp, req, lkpBlocked, exp);
  endtask

  task automatic unblock(input bit isCache, input logic [1:0] slot);
    @(negedge clk);
    unbValid = 1; unbIsCache = isCache; unbSlot = slot;
    @(negedge clk);
    unbValid = 0;
  endtask

  function automatic bit logIs(input int a[$]);
    if (a.size() != evLog.size()) return 0;
    foreach (a[i]) if (a[i] != evLog[i]) return 0;
    return 1;
  endfunction

  localparam logic [39:0] A_ADDR = 40'h12_3456_7800;
  localparam logic [39:0] B_ADDR = 40'hAB_0000_0040;
  localparam logic [39:0] C_ADDR = 40'h00_FFFF_0080;
  localparam logic [39:0] D_ADDR = 40'h77_1000_0000;
  localparam logic [39:0] E_ADDR = 40'h01_0203_0400;

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // reset state
    chk(cmdReady == 1, "R1 ready after reset", cmdReady, 1);
    chk({drainReq, flushReq, wholeReq} == 0, "R12 no request after reset", {drainReq, flushReq, wholeReq}, 0);
    chk(stsValid == 0, "R10 no status after reset", stsValid, 0);
    lookup(A_ADDR, 0, "R5 nothing blocked after reset");

    // plain flush with status
    issue(16'h0001, 1, A_ADDR, 0, 0, 0, 0, 0, 0, 0, 2'b00);
    chk(logIs('{2}), "R12 plain flush single request", evLog.size(), 1);
    chk(sawKeep == 0, "R9 keep low", sawKeep, 0);

    // keep-valid flush, no status requested
    issue(16'h0002, 0, A_ADDR, 0, 0, 0, 0, 1, 0, 0, 2'b00);
    chk(logIs('{2}), "R9 keep flush single request", evLog.size(), 1);
    chk(sawKeep == 1, "R9 keep high", sawKeep, 1);

    // drain then primary then companion
    issue(16'h0003, 1, A_ADDR, 0, 0, 0, 0, 0, 1, 1, 2'b00);
    chk(logIs('{1, 2, 3}), "R7 R8 drain, primary, companion order", evLog.size(), 3);

    // block slot 1 on B
    issue(16'h0004, 1, B_ADDR, 1, 0, 1, 0, 0, 0, 0, 2'b00);
    lookup(B_ADDR, 1, "R5 B blocked by slot 1");
    lookup(A_ADDR, 0, "R5 A not blocked");

    // block held slot 1 without release: error 10
    issue(16'h0005, 1, C_ADDR, 1, 0, 1, 0, 0, 0, 0, 2'b10);
    chk(evLog.size() == 0, "R3 no request on held slot", evLog.size(), 0);
    lookup(C_ADDR, 0, "R3 C not captured");
    lookup(B_ADDR, 1, "R3 slot keeps B");

    // release a free slot: error 01
    issue(16'h0006, 1, D_ADDR, 2, 1, 0, 0, 0, 0, 0, 2'b01);
    chk(evLog.size() == 0, "R2 no request on free slot release", evLog.size(), 0);
    lookup(B_ADDR, 1, "R2 slot table unchanged");

    // release slot 1 and re-block on C; probe B during flush
    lkpAddr = B_ADDR;
    issue(16'h0007, 1, C_ADDR, 1, 1, 1, 0, 0, 0, 0, 2'b00);
    chk(probeAtFlush == 0, "R4 slot freed before flush", probeAtFlush, 0);
    lookup(C_ADDR, 1, "R5 C blocked after re-block");
    lookup(B_ADDR, 0, "R4 B free after release");

    // whole cache with other options set that must be ignored
    issue(16'h0008, 1, D_ADDR, 3, 1, 1, 1, 1, 1, 1, 2'b00);
    chk(logIs('{4}), "R6 only whole-cache request", evLog.size(), 1);
    lookup(E_ADDR, 1, "R6 any address blocked after whole flush");
    unblock(1, 0);
    lookup(E_ADDR, 0, "R11 cache unblock clears whole block");
    lookup(D_ADDR, 0, "R6 slot 3 not captured");
    lookup(C_ADDR, 1, "R6 slot 1 unchanged");

    // unblock slot 1
    unblock(0, 1);
    lookup(C_ADDR, 0, "R11 slot unblock frees C");

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R10 all status records seen", expQ.size(), 0);
    finish_run();
  end
endmodule